// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

The block divides a fast input clock by a programmable ratio, as the feedback divider of a frequency synthesizer loop. A dual-modulus prescaler counts input clocks in cycles of either 32 or 33. A main counter of 10 bits (value M) and a swallow counter of 5 bits (value S) decide how many prescaler cycles make up one main cycle and how many of those use the longer modulus. One main cycle therefore lasts 32M + S input clocks. A trailing divide-by-8 stage turns eight main cycles into one output pulse, so the whole ratio is N = 8 × (32M + S), from 8192 to 262136.

The ratio words are sampled only when a main cycle ends, and at reset, so a word written at any moment takes effect at the next main-cycle boundary and never shortens or stretches a cycle already running. A main value below 32 would let the swallow count overrun the main count; such a value is treated as 32 and a flag reports that the substitution happened. The prescaler is modelled as a synthesizable counter running on the same clock, and its mode is also brought out as a port.

Top module: `swallow_divider`

## Requirements
- R1: While reset is high and on the first cycle after it, div_pulse is 0, mode_33 is 1 exactly when s_word is nonzero, and m_clamped is 1 exactly when m_word is below 32.
- R2: With m_word and s_word held constant, consecutive div_pulse assertions are N = 8 × (32M' + S) clocks apart, where M' is m_word raised to 32 if it is smaller.
- R3: div_pulse is high for exactly one clock per output period.
- R4: In every main cycle mode_33 is high for 33·S clocks (the first S prescaler cycles, each 33 clocks long) and low for the remaining 32·(M' − S) clocks; with S = 0 it stays low for the whole period. Per output period it is therefore high for 264·S clocks.
- R5: A change of m_word or s_word takes effect only at the next main-cycle boundary: changed just after a pulse, the next interval is (32Mold' + Sold) + 7 × (32Mnew' + Snew) clocks and mode_33 is high for 33·(Sold + 7·Snew) of them, and m_clamped keeps its old value until that boundary.
- R6: An m_word below 32 is divided as 32, and m_clamped is 1 from the boundary at which such a value is taken until the boundary at which a value of 32 or more is taken.
- R7: The first div_pulse after reset is released appears exactly N clock edges after the first edge with reset low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider input clock (prescaler input) |
| rst | input | 1 | Synchronous active-high reset; loads the ratio words |
| m_word | input | 10 | Main count M, legal 32..1023 |
| s_word | input | 5 | Swallow count S, 0..31 |
| mode_33 | output | 1 | Prescaler modulus: 1 = divide by 33, 0 = divide by 32 |
| div_pulse | output | 1 | One-clock pulse per completed division by N |
| m_clamped | output | 1 | High while the loaded main count was raised to 32 |

## Verification
The assertions take nothing for granted about m_word and s_word: they may change on any clock, and legality of the swallow count against the main count is enforced inside by the clamp, which is exactly what the in-range checks rely on. They do assume reset is held for at least one edge before the first checked cycle. The stimulus changes the ratio words only a few nanoseconds after an observed output pulse, so every interval is either a steady period or a single one-boundary transition whose clock count and high-modulus time can be predicted exactly.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

    localparam int M_W      = 10;
    localparam int S_W      = 5;
    localparam int POST_DIV = 8;
    localparam int PRE_BASE = 1 << S_W;
    localparam int M_MIN    = PRE_BASE;

    typedef enum logic {
        MOD_BASE = 1'b0,
        MOD_PLUS = 1'b1
    } mode_t;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [S_W-1:0] s;
    } ratio_t;

    function automatic logic below_min(input logic [M_W-1:0] m);
        return m < M_W'(M_MIN);
    endfunction

    function automatic ratio_t fix_ratio(input logic [M_W-1:0] m,
                                         input logic [S_W-1:0] s);
        ratio_t r;
        r.m = below_min(m) ? M_W'(M_MIN) : m;
        r.s = s;
        return r;
    endfunction

endpackage

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
    import swdiv_pkg::*;
#(
    parameter int BASE = PRE_BASE
) (
    input  logic  clk,
    input  logic  rst,
    input  mode_t mode,
    output logic  cyc_done
);
    localparam int PC_W = $clog2(BASE + 1);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] last;

    always_comb begin
        last     = (mode == MOD_PLUS) ? PC_W'(BASE) : PC_W'(BASE - 1);
        cyc_done = (pc_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (cyc_done)
            pc_q <= '0;
        else
            pc_q <= pc_q + 1'b1;
    end

    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (pc_q != '0) |-> $stable(mode)); // R4

endmodule

// File: rtl/swdiv_counters.sv
module swdiv_counters
    import swdiv_pkg::*;
#(
    parameter int MW = M_W,
    parameter int SW = S_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pre_done,
    input  logic [MW-1:0] m_in,
    input  logic [SW-1:0] s_in,
    output mode_t         mode,
    output logic          main_end,
    output logic          m_low
);
    logic [MW-1:0] m_rem;
    logic [SW-1:0] s_rem;
    ratio_t        eff;

    always_comb begin
        eff      = fix_ratio(m_in, s_in);
        mode     = (s_rem != '0) ? MOD_PLUS : MOD_BASE;
        main_end = pre_done && (m_rem == MW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || main_end) begin
            m_rem <= eff.m;
            s_rem <= eff.s;
            m_low <= below_min(m_in);
        end else if (pre_done) begin
            m_rem <= m_rem - 1'b1;
            if (s_rem != '0)
                s_rem <= s_rem - 1'b1;
        end
    end

    AST_S_WITHIN_M: assert property (@(posedge clk) disable iff (rst)
        (s_rem != '0) |-> ({{(MW-SW){1'b0}}, s_rem} <= m_rem)); // R6

    AST_RELOAD_MIN: assert property (@(posedge clk) disable iff (rst)
        main_end |=> (m_rem >= MW'(M_MIN))); // R6

endmodule

// File: rtl/swdiv_post.sv
module swdiv_post #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic pulse
);
    localparam int Q_W = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_count
            logic [Q_W-1:0] q;
            logic           wrap;

            always_comb wrap = (q == Q_W'(DIV - 1));

            always_ff @(posedge clk) begin
                if (rst) begin
                    q     <= '0;
                    pulse <= 1'b0;
                end else begin
                    pulse <= tick && wrap;
                    if (tick)
                        q <= wrap ? '0 : q + 1'b1;
                end
            end
        end else begin : g_pass
            always_ff @(posedge clk) begin
                if (rst)
                    pulse <= 1'b0;
                else
                    pulse <= tick;
            end
        end
    endgenerate

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        (pulse && (DIV > 1)) |=> !pulse); // R3

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swdiv_pkg::*;
#(
    parameter int POST = POST_DIV
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [M_W-1:0] m_word,
    input  logic [S_W-1:0] s_word,
    output logic           mode_33,
    output logic           div_pulse,
    output logic           m_clamped
);
    mode_t mode;
    logic  pre_done;
    logic  main_end;

    swdiv_prescaler #(.BASE(PRE_BASE)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .cyc_done (pre_done)
    );

    swdiv_counters #(.MW(M_W), .SW(S_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .pre_done (pre_done),
        .m_in     (m_word),
        .s_in     (s_word),
        .mode     (mode),
        .main_end (main_end),
        .m_low    (m_clamped)
    );

    swdiv_post #(.DIV(POST)) u_post (
        .clk   (clk),
        .rst   (rst),
        .tick  (main_end),
        .pulse (div_pulse)
    );

    assign mode_33 = (mode == MOD_PLUS);

    AST_MODE_AT_PULSE: assert property (@(posedge clk) disable iff (rst)
        $rose(div_pulse) |-> $past(pre_done)); // R2

endmodule

// File: tb/swallow_divider_test.sv
module swallow_divider_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] m_word;
    logic [4:0] s_word;
    logic       mode_33;
    logic       div_pulse;
    logic       m_clamped;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        int ivl;
        int hi;
        int kind; // 0 first after reset, 1 steady, 2 transition
    } exp_t;

    exp_t exp_q[$];

    swallow_divider uut (
        .clk       (clk),
        .rst       (rst),
        .m_word    (m_word),
        .s_word    (s_word),
        .mode_33   (mode_33),
        .div_pulse (div_pulse),
        .m_clamped (m_clamped)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int unit(input int m, input int s);
        return 32 * ((m < 32) ? 32 : m) + s;
    endfunction

    task automatic push_steady(input int m, input int s, input int kind);
        exp_t e;
        e.ivl = 8 * unit(m, s);
        e.hi = 8 * 33 * s;
        e.kind = kind;
        exp_q.push_back(e);
    endtask

    task automatic push_trans(input int mo, input int so, input int mn, input int sn);
        exp_t e;
        e.ivl = unit(mo, so) + 7 * unit(mn, sn);
        e.hi = 33 * (so + 7 * sn);
        e.kind = 2;
        exp_q.push_back(e);
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!div_pulse);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // monitor / scoreboard
    int cyc = 0;
    int acc = 0;
    bit prev_pulse = 0;
    always @(negedge clk) begin
        if (rst) begin
            cyc = 0;
            acc = mode_33 ? 1 : 0;
            prev_pulse = 0;
        end else begin
            cyc++;
            if (prev_pulse)
                check(div_pulse == 1'b0, "R3 pulse width", int'(div_pulse), 0);
            if (div_pulse) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected pulse", cyc, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.kind == 0)
                        check(cyc == e.ivl, "R7 first interval", cyc, e.ivl);
                    else if (e.kind == 1)
                        check(cyc == e.ivl, "R2 interval", cyc, e.ivl);
                    else
                        check(cyc == e.ivl, "R5 transition interval", cyc, e.ivl);
                    check(acc == e.hi, "R4 mode_33 high clocks", acc, e.hi);
                end
                cyc = 0;
                acc = 0;
            end
            prev_pulse = div_pulse;
            acc += mode_33 ? 1 : 0;
        end
    end

    initial begin
        rst = 1'b1;
        m_word = 10'd32;
        s_word = 5'd0;
        repeat (5) @(negedge clk);
        check(div_pulse == 1'b0, "R1 div_pulse in reset", int'(div_pulse), 0);
        check(mode_33 == 1'b0, "R1 mode_33 in reset", int'(mode_33), 0);
        check(m_clamped == 1'b0, "R1 m_clamped in reset", int'(m_clamped), 0);
        push_steady(32, 0, 0);
        push_steady(32, 0, 1);
        #2 rst = 1'b0;
        @(negedge clk);
        check(div_pulse == 1'b0, "R1 div_pulse after reset", int'(div_pulse), 0);
        wait_pulse();
        wait_pulse();

        // longest swallow count
        #2 m_word = 10'd32; s_word = 5'd31;
        push_trans(32, 0, 32, 31);
        push_steady(32, 31, 1);
        wait_pulse();
        wait_pulse();

        // main count below minimum: clamped
        #2 m_word = 10'd5; s_word = 5'd3;
        #1 check(m_clamped == 1'b0, "R5 flag held until boundary", int'(m_clamped), 0);
        push_trans(32, 31, 5, 3);
        push_steady(5, 3, 1);
        wait_pulse();
        check(m_clamped == 1'b1, "R6 flag raised", int'(m_clamped), 1);
        wait_pulse();
        check(m_clamped == 1'b1, "R6 flag stays", int'(m_clamped), 1);

        // back into range
        #2 m_word = 10'd64; s_word = 5'd31;
        #1 check(m_clamped == 1'b1, "R5 flag held until boundary", int'(m_clamped), 1);
        push_trans(5, 3, 64, 31);
        push_steady(64, 31, 1);
        wait_pulse();
        check(m_clamped == 1'b0, "R6 flag cleared", int'(m_clamped), 0);
        wait_pulse();

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all pulses seen", exp_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", exp_q.size(), 0);
            summary();
            $finish;
        end
    end

endmodule